// File: doc/BRIEF.md
# Oversampling UART baud generator

This block turns a kernel clock into the timing ticks a UART receiver or transmitter needs. A 16-bit divisor register says how many kernel-clock cycles make up one bit. The block splits each bit period into 16 or 8 oversample ticks. It also raises a strobe at the middle of each bit, where a receiver samples the line.

The divisor is packed differently in the two oversampling modes. When oversampling by 16, the whole register is the divider. When oversampling by 8, the register carries a mantissa in its upper bits and a halved fraction in its lowest three bits, and the block rebuilds the divider from them. The divisor and the mode are configuration. They are taken only while the block is disabled. Dropping the enable clears all timing state, so every bit stream starts from the same phase.

The block does not have a divider to make the ticks. It accumulates the oversampling ratio each cycle and subtracts the divider when the sum reaches it. The result is exactly 16 (or 8) ticks per bit period, with any fractional remainder spread across the bit.

Top module: `ovs_baud_gen`

## Requirements
- R1: After reset the mode is oversampling by 16 and the divisor is zero. Both outputs are low during reset, and they stay low when the block is enabled with no divisor written.
- R2: With `ovs8_sel` low (oversample by 16), the effective divider D is the full 16-bit divisor value. Exactly 16 `os_tick` pulses occur in every D enabled cycles.
- R3: With `ovs8_sel` high (oversample by 8), D is divisor[15:4] in bits 15:4, then divisor[2:0] in bits 3:1, and a zero in bit 0. Divisor bit 3 has no effect. Exactly 8 `os_tick` pulses occur in every D enabled cycles.
- R4: In the by-8 mode the smallest legal divider, D = 8, gives an `os_tick` on every enabled cycle. The maximum rate is therefore one bit per 8 kernel cycles.
- R5: Let n count the enabled clock edges since the enable rose, starting at 1. With N = 16 or 8, `os_tick` is high in the cycle after edge n exactly when floor(n*N/D) exceeds floor((n-1)*N/D). Consecutive ticks are therefore floor(D/N) or ceil(D/N) cycles apart.
- R6: `bit_mid` pulses together with `os_tick` on the 8th tick (by 16) or the 4th tick (by 8) of each bit. In the R5 numbering, this is where floor(n*N/D) mod N equals N/2.
- R7: A divisor write (`div_wr`) and any change of `ovs8_sel` take effect only on clock edges where `en` is low. While `en` is high they are ignored, and the tick timing continues unchanged.
- R8: While `en` is low, both outputs stay low and the timing state is cleared. After the enable is raised again, the first tick follows edge n = ceil(D/N).
- R9: A divider below N (D < 16 by 16, D < 8 by 8, including zero) is illegal. No ticks or strobes occur while it is configured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_k | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Peripheral enable; configuration is frozen while high |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W (16) | Divisor write value |
| ovs8_sel | input | 1 | Oversampling select: 0 = by 16, 1 = by 8 |
| os_tick | output | 1 | Oversample tick, one cycle wide |
| bit_mid | output | 1 | Bit-centre strobe, one cycle wide |

## Verification
The hardest case to reach is a write and a mode change that arrive while the block is running. Proving they were ignored means the old tick timing must continue, and the new values must never surface later. The stimulus issues such a write mid-bit, then disables the block. After disabling, the stored divisor shows through a changed tick spacing, and a divisor that leaked in would show a very different one. Fractional spacing and the by-8 decode are also exercised, using divisors whose naive reading gives a different first-tick cycle and different gaps. A cycle-by-cycle behavioural reference model checks every output.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
    typedef enum logic {
        OVS_16 = 1'b0,
        OVS_8  = 1'b1
    } ovs_e;

    localparam int unsigned OSR_WIDE   = 16;
    localparam int unsigned OSR_NARROW = 8;
    localparam int unsigned SUB_W      = $clog2(OSR_WIDE);
endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
    import baudgen_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk_k,
    input  logic             rst_n,
    input  logic             en,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             ovs8_sel,
    output logic [DIV_W-1:0] eff_div,
    output ovs_e             mode,
    output logic             legal
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        ovs_e             mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Configuration only moves while the peripheral is disabled
    always_comb begin
        cfg_d = cfg_q;
        if (!en) begin
            cfg_d.mode = ovs8_sel ? OVS_8 : OVS_16;
            if (div_wr) begin
                cfg_d.div = div_wdata;
            end
        end
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{div: '0, mode: OVS_16};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Divider decode: packed mantissa/half-fraction in by-8 mode, bit 3 unused
    logic [DIV_W-1:0] osr_val;
    always_comb begin
        if (cfg_q.mode == OVS_8) begin
            eff_div = {cfg_q.div[DIV_W-1:4], cfg_q.div[2:0], 1'b0};
            osr_val = DIV_W'(OSR_NARROW);
        end else begin
            eff_div = cfg_q.div;
            osr_val = DIV_W'(OSR_WIDE);
        end
        legal = (eff_div >= osr_val);
    end

    assign mode = cfg_q.mode;

    // R7: stored configuration never moves across an enabled edge
    p_cfg_frozen_r7: assert property (@(posedge clk_k) disable iff (!rst_n)
        en |=> $stable(cfg_q));
endmodule

// File: rtl/baud_tick.sv
module baud_tick
    import baudgen_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk_k,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] eff_div,
    input  ovs_e             mode,
    output logic             os_tick,
    output logic             bit_mid
);
    typedef struct packed {
        logic [DIV_W-1:0] acc;
        logic [SUB_W-1:0] sub;
        logic             tick;
        logic             mid;
    } tick_st_t;

    tick_st_t st_d, st_q;

    logic [DIV_W:0]   step;
    logic [DIV_W:0]   sum;
    logic [DIV_W:0]   rem;
    logic [SUB_W-1:0] mid_sub;
    logic [SUB_W-1:0] last_sub;

    always_comb begin
        if (mode == OVS_8) begin
            step     = (DIV_W+1)'(OSR_NARROW);
            mid_sub  = SUB_W'(OSR_NARROW / 2 - 1);
            last_sub = SUB_W'(OSR_NARROW - 1);
        end else begin
            step     = (DIV_W+1)'(OSR_WIDE);
            mid_sub  = SUB_W'(OSR_WIDE / 2 - 1);
            last_sub = SUB_W'(OSR_WIDE - 1);
        end
        sum = {1'b0, st_q.acc} + step;
        rem = sum - {1'b0, eff_div};

        st_d = '0;
        if (run) begin
            st_d.sub = st_q.sub;
            if (sum >= {1'b0, eff_div}) begin
                st_d.acc  = rem[DIV_W-1:0];
                st_d.tick = 1'b1;
                st_d.mid  = (st_q.sub == mid_sub);
                st_d.sub  = (st_q.sub == last_sub) ? '0 : st_q.sub + 1'b1;
            end else begin
                st_d.acc  = sum[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign os_tick = st_q.tick;
    assign bit_mid = st_q.mid;
endmodule

// File: rtl/ovs_baud_gen.sv
module ovs_baud_gen
    import baudgen_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk_k,
    input  logic             rst_n,
    input  logic             en,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             ovs8_sel,
    output logic             os_tick,
    output logic             bit_mid
);
    logic [DIV_W-1:0] eff_div;
    ovs_e             mode;
    logic             legal;

    baud_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk_k     (clk_k),
        .rst_n     (rst_n),
        .en        (en),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .ovs8_sel  (ovs8_sel),
        .eff_div   (eff_div),
        .mode      (mode),
        .legal     (legal)
    );

    baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk_k   (clk_k),
        .rst_n   (rst_n),
        .run     (en && legal),
        .eff_div (eff_div),
        .mode    (mode),
        .os_tick (os_tick),
        .bit_mid (bit_mid)
    );

    // R6: the centre strobe only ever lands on an oversample tick
    p_mid_on_tick_r6: assert property (@(posedge clk_k) disable iff (!rst_n)
        bit_mid |-> os_tick);

    // R9: an illegal divider produces no tick
    p_illegal_quiet_r9: assert property (@(posedge clk_k) disable iff (!rst_n)
        (en && !legal) |=> !os_tick);

    // R4: by-8 with divider 8 ticks on every enabled cycle
    p_x8_full_rate_r4: assert property (@(posedge clk_k) disable iff (!rst_n)
        (en && $past(en) && mode == OVS_8 && eff_div == DIV_W'(8)) |-> os_tick);

    // R8: disabled edges leave the outputs low
    p_idle_quiet_r8: assert property (@(posedge clk_k) disable iff (!rst_n)
        !en |=> (!os_tick && !bit_mid));
endmodule

// File: tb/ovs_baud_gen_bench.sv
module ovs_baud_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk_k = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        ovs8_sel = 1'b0;
    logic        os_tick;
    logic        bit_mid;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk_k = ~clk_k;

    ovs_baud_gen u_ovs_baud_gen (
        .clk_k     (clk_k),
        .rst_n     (rst_n),
        .en        (en),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .ovs8_sel  (ovs8_sel),
        .os_tick   (os_tick),
        .bit_mid   (bit_mid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    longint m_n = 0;
    int     m_div = 0;
    bit     m_x8 = 0;
    bit     exp_tick = 0, exp_mid = 0;

    always @(posedge clk_k) begin
        longint d, nn, j, jp;
        if (!rst_n) begin
            m_n = 0; m_div = 0; m_x8 = 0; exp_tick = 0; exp_mid = 0;
        end else begin
            if (m_x8) d = ((m_div >> 4) << 4) | ((m_div & 7) << 1);
            else      d = m_div;
            nn = m_x8 ? 8 : 16;
            if (!en || d < nn) begin
                m_n = 0; exp_tick = 0; exp_mid = 0;
            end else begin
                m_n++;
                j  = (m_n * nn) / d;
                jp = ((m_n - 1) * nn) / d;
                exp_tick = (j != jp);
                exp_mid  = exp_tick && ((j % nn) == nn / 2);
            end
            if (!en) begin
                m_x8 = ovs8_sel;
                if (div_wr) m_div = int'(div_wdata);
            end
        end
    end

    always @(negedge clk_k) begin
        check(os_tick == exp_tick, cur_req, "os_tick vs model", os_tick, exp_tick);
        check(bit_mid == exp_mid, cur_req, "bit_mid vs model", bit_mid, exp_mid);
    end

    task automatic wr_div(input logic [15:0] v);
        @(negedge clk_k);
        div_wr = 1'b1; div_wdata = v;
        @(negedge clk_k);
        div_wr = 1'b0;
    endtask

    task automatic disable_blk();
        @(negedge clk_k);
        en = 1'b0;
        @(negedge clk_k);
    endtask

    // Enable and observe: tick count, strobe count, gap range, first tick index
    task automatic measure(input int cycles, input bit poke,
                           output int t, output int m,
                           output int gmin, output int gmax, output int first);
        int last;
        t = 0; m = 0; gmin = 1 << 30; gmax = 0; first = 0; last = 0;
        @(negedge clk_k);
        en = 1'b1;
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk_k);
            if (poke && i == 5) begin
                div_wr = 1'b1; div_wdata = 16'h0020; ovs8_sel = 1'b1;
            end else if (poke && i == 6) begin
                div_wr = 1'b0;
            end
            #1;
            if (os_tick) begin
                t++;
                if (first == 0) first = i;
                else begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
            if (bit_mid) m++;
        end
    endtask

    initial begin
        int t, m, gmin, gmax, first;
        cur_req = "R1";
        repeat (4) @(negedge clk_k);
        check(os_tick == 1'b0, "R1", "os_tick in reset", os_tick, 0);
        check(bit_mid == 1'b0, "R1", "bit_mid in reset", bit_mid, 0);
        rst_n = 1'b1;
        measure(100, 0, t, m, gmin, gmax, first);
        check(t == 0, "R1", "ticks with reset divisor", t, 0);
        disable_blk();

        cur_req = "R2";
        ovs8_sel = 1'b0;
        wr_div(16'd160);
        measure(640, 0, t, m, gmin, gmax, first);
        check(t == 64, "R2", "ticks in 4 bits x16 D=160", t, 64);
        check(gmin == 10 && gmax == 10, "R2", "gap x16 D=160", gmax, 10);
        check(m == 4, "R6", "centre strobes in 4 bits", m, 4);
        check(first == 10, "R8", "first tick x16 D=160", first, 10);
        disable_blk();

        cur_req = "R5";
        wr_div(16'd165);
        measure(495, 0, t, m, gmin, gmax, first);
        check(t == 48, "R5", "ticks in 3 bits D=165", t, 48);
        check(gmin == 10, "R5", "min gap D=165", gmin, 10);
        check(gmax == 11, "R5", "max gap D=165", gmax, 11);
        check(m == 3, "R6", "centre strobes D=165", m, 3);

        cur_req = "R8";
        disable_blk();
        measure(495, 0, t, m, gmin, gmax, first);
        check(first == 11, "R8", "first tick after re-enable", first, 11);
        check(t == 48, "R8", "ticks after re-enable", t, 48);
        disable_blk();

        cur_req = "R3";
        ovs8_sel = 1'b1;
        wr_div(16'h00A7);
        measure(348, 0, t, m, gmin, gmax, first);
        check(t == 16, "R3", "ticks in 2 bits x8 D=174", t, 16);
        check(first == 22, "R3", "first tick x8 D=174", first, 22);
        check(gmin == 21 && gmax == 22, "R3", "gap range x8 D=174", gmin, 21);
        check(m == 2, "R6", "centre strobes x8", m, 2);
        disable_blk();
        wr_div(16'h00AF);
        measure(348, 0, t, m, gmin, gmax, first);
        check(t == 16 && first == 22, "R3", "bit 3 ignored first tick", first, 22);
        disable_blk();

        cur_req = "R4";
        wr_div(16'h0004);
        measure(50, 0, t, m, gmin, gmax, first);
        check(t == 50, "R4", "x8 D=8 tick every cycle", t, 50);
        check(m == 6, "R6", "centre strobes x8 D=8", m, 6);
        disable_blk();

        cur_req = "R7";
        ovs8_sel = 1'b0;
        wr_div(16'd160);
        measure(640, 1, t, m, gmin, gmax, first);
        check(t == 64, "R7", "ticks unchanged by enabled write", t, 64);
        check(gmin == 10 && gmax == 10, "R7", "gap unchanged by enabled write", gmax, 10);
        disable_blk();
        measure(160, 0, t, m, gmin, gmax, first);
        check(first == 20, "R7", "divisor kept 160, mode x8 taken when disabled", first, 20);
        check(t == 8, "R7", "ticks x8 D=160", t, 8);
        disable_blk();

        cur_req = "R9";
        ovs8_sel = 1'b0;
        wr_div(16'd15);
        measure(100, 0, t, m, gmin, gmax, first);
        check(t == 0 && m == 0, "R9", "x16 D=15 quiet", t, 0);
        disable_blk();
        wr_div(16'd16);
        measure(32, 0, t, m, gmin, gmax, first);
        check(t == 32, "R9", "x16 D=16 boundary legal", t, 32);
        disable_blk();
        ovs8_sel = 1'b1;
        wr_div(16'h0003);
        measure(100, 0, t, m, gmin, gmax, first);
        check(t == 0 && m == 0, "R9", "x8 D=6 quiet", t, 0);
        disable_blk();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_k);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule